// File: doc/BRIEF.md
# Execute Stage: ALU, Condition Flags and Branch Decision

This block is the execute step of a processor that finishes each instruction in one cycle. From the instruction code it picks the two ALU operands. Operand A can be the register operand, the instruction constant, or a fixed stack adjustment of plus or minus four. Operand B is the second register operand or zero. The block then applies one of four operations to give the result `val_e`.

A three-bit flag register (zero, sign, signed overflow) captures the ALU outcome on the rising clock edge, but only for arithmetic/logical instructions. A jump instruction is judged against the stored flags, never against the current ALU output. The branch decision `take_branch` is produced in the same cycle. Memory access and register write-back are handled elsewhere.

Instruction codes (`icode`): 0 halt, 1 nop, 2 register move, 3 immediate move, 4 register-to-memory move, 5 memory-to-register move, 6 ALU op, 7 jump, 8 call, 9 return, 10 push, 11 pop.

Top module: `exec_unit`

## Requirements
- R1: Operand A is `val_a` for icode 2 and 6, `val_c` for icode 3, 4 and 5, the constant -4 for icode 8 and 10, the constant +4 for icode 9 and 11, and 0 for all other codes.
- R2: Operand B is 0 for icode 2 and 3 and `val_b` for every other code.
- R3: For icode 6 the operation comes from `ifun`: 0 adds (B+A), 1 subtracts (B-A), 2 is bitwise AND, 3 is bitwise XOR. Every other icode adds. `val_e` is combinational.
- R4: While `rst` is high the flags are zero=1, sign=0, overflow=0.
- R5: The flags load on a rising clock edge only when icode is 6. On any other code they hold their value.
- R6: On a load, zero is set when the result is all zeros, and sign takes the result's most significant bit.
- R7: On a load, overflow is signed two's-complement overflow for add and subtract, and is 0 for AND and XOR.
- R8: For icode 7, `take_branch` is evaluated from the stored flags, with x = sign XOR overflow. The `ifun` codes are: 0 always, 1 x|zero, 2 x, 3 zero, 4 !zero, 5 !x, 6 !x & !zero.
- R9: `take_branch` is 0 for any icode other than 7, and for icode 7 with `ifun` 7 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| icode | input | 4 | Instruction code |
| ifun | input | 4 | Function / condition code |
| val_a | input | WIDTH | First register operand |
| val_b | input | WIDTH | Second register operand |
| val_c | input | WIDTH | Instruction constant |
| val_e | output | WIDTH | ALU result |
| take_branch | output | 1 | Jump taken |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |

## Verification
The bench builds the block with WIDTH set to 8. At that width, the wrap of -4 into 0xFC and the signed limits 0x7F and 0x80 are easy to hit with plain constants. Both overflow directions, a zero result from subtraction, and overflow being cleared by a logical operation can therefore all be exercised directly. Every jump condition, including the unused codes, is then tested against flag states that the bench has reached.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       icode,
  input  logic [3:0]       ifun,
  input  logic [WIDTH-1:0] val_a,
  input  logic [WIDTH-1:0] val_b,
  input  logic [WIDTH-1:0] val_c,
  output logic [WIDTH-1:0] val_e,
  output logic             take_branch,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_o
);
  localparam logic [3:0] C_RRMOV = 4'd2, C_IRMOV = 4'd3, C_RMMOV = 4'd4,
                         C_MRMOV = 4'd5, C_OP    = 4'd6, C_JMP   = 4'd7,
                         C_CALL  = 4'd8, C_RET   = 4'd9, C_PUSH  = 4'd10,
                         C_POP   = 4'd11;
  localparam logic [WIDTH-1:0] PLUS4  = WIDTH'(4);
  localparam logic [WIDTH-1:0] MINUS4 = -PLUS4;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] op_a, op_b;
  logic [1:0]       fn;
  logic             ovf, x;

  always_comb begin
    case (icode)
      C_RRMOV, C_OP:             op_a = val_a;
      C_IRMOV, C_RMMOV, C_MRMOV: op_a = val_c;
      C_CALL, C_PUSH:            op_a = MINUS4;
      C_RET, C_POP:              op_a = PLUS4;
      default:                   op_a = '0;
    endcase
  end

  assign op_b = (icode == C_RRMOV || icode == C_IRMOV) ? '0 : val_b;
  assign fn   = (icode == C_OP) ? ifun[1:0] : 2'd0;

  always_comb begin
    case (fn)
      2'd0:    val_e = op_b + op_a;
      2'd1:    val_e = op_b - op_a;
      2'd2:    val_e = op_b & op_a;
      default: val_e = op_b ^ op_a;
    endcase
  end

  always_comb begin
    case (fn)
      2'd0:    ovf = (op_a[MSB] == op_b[MSB]) && (val_e[MSB] != op_a[MSB]);
      2'd1:    ovf = (op_a[MSB] != op_b[MSB]) && (val_e[MSB] != op_b[MSB]);
      default: ovf = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b1;
      flag_s <= 1'b0;
      flag_o <= 1'b0;
    end else if (icode == C_OP) begin
      flag_z <= (val_e == '0);
      flag_s <= val_e[MSB];
      flag_o <= ovf;
    end
  end

  assign x = flag_s ^ flag_o;

  always_comb begin
    take_branch = 1'b0;
    if (icode == C_JMP) begin
      case (ifun)
        4'd0:    take_branch = 1'b1;
        4'd1:    take_branch = x | flag_z;
        4'd2:    take_branch = x;
        4'd3:    take_branch = flag_z;
        4'd4:    take_branch = !flag_z;
        4'd5:    take_branch = !x;
        4'd6:    take_branch = !x && !flag_z;
        default: take_branch = 1'b0;
      endcase
    end
  end

  a_r4_reset_flags: assert property (@(posedge clk)
    rst |=> (flag_z && !flag_s && !flag_o));
  a_r5_hold_flags: assert property (@(posedge clk) disable iff (rst)
    (icode != C_OP) |=> $stable({flag_z, flag_s, flag_o}));
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (icode == C_OP) |=> (flag_z == ($past(val_e) == '0)));
  a_r7_logic_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (icode == C_OP && ifun[1]) |=> !flag_o);
  a_r8_always_jump: assert property (@(posedge clk) disable iff (rst)
    (icode == C_JMP && ifun == 4'd0) |-> take_branch);
  a_r9_no_branch: assert property (@(posedge clk) disable iff (rst)
    (icode != C_JMP) |-> !take_branch);
endmodule

// File: tb/test_exec_unit.sv
module test_exec_unit;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] icode = 4'd1, ifun = 4'd0;
  logic [W-1:0] val_a = '0, val_b = '0, val_c = '0;
  logic [W-1:0] val_e;
  logic take_branch, flag_z, flag_s, flag_o;

  exec_unit #(.WIDTH(W)) i_exec_unit (
    .clk(clk), .rst(rst), .icode(icode), .ifun(ifun),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .take_branch(take_branch),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [W-1:0] e;
    logic         br;
    logic [2:0]   f;
    logic [3:0]   ic;
    logic [3:0]   fu;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0;
  logic [2:0] mf = 3'b100;
  bit done = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [3:0] ic, input logic [3:0] fu,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] oa, ob, r;
    logic [1:0] f;
    logic z, s, o, xx, br;
    item_t it;
    @(negedge clk);
    icode = ic; ifun = fu; val_a = a; val_b = b; val_c = c;
    case (ic)
      4'd2, 4'd6:       oa = a;
      4'd3, 4'd4, 4'd5: oa = c;
      4'd8, 4'd10:      oa = 8'hFC;
      4'd9, 4'd11:      oa = 8'h04;
      default:          oa = 8'h00;
    endcase
    ob = (ic == 4'd2 || ic == 4'd3) ? 8'h00 : b;
    f = (ic == 4'd6) ? fu[1:0] : 2'd0;
    case (f)
      2'd0: begin r = ob + oa; o = (oa[7] == ob[7]) && (r[7] != oa[7]); end
      2'd1: begin r = ob - oa; o = (oa[7] != ob[7]) && (r[7] != ob[7]); end
      2'd2: begin r = ob & oa; o = 1'b0; end
      default: begin r = ob ^ oa; o = 1'b0; end
    endcase
    z = mf[2]; s = mf[1];
    xx = mf[1] ^ mf[0];
    br = 1'b0;
    if (ic == 4'd7)
      case (fu)
        4'd0: br = 1'b1;
        4'd1: br = xx | z;
        4'd2: br = xx;
        4'd3: br = z;
        4'd4: br = !z;
        4'd5: br = !xx;
        4'd6: br = !xx && !z;
        default: br = 1'b0;
      endcase
    if (ic == 4'd6) mf = {r == 8'h00, r[7], o};
    it.e = r; it.br = br; it.f = mf; it.ic = ic; it.fu = fu;
    q.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        // R1 R2 R3: result; R8 R9: branch decision
        check($sformatf("R1/R2/R3 val_e ic=%0d fn=%0d", it.ic, it.fu), 16'(val_e), 16'(it.e));
        check($sformatf("R8/R9 branch ic=%0d fn=%0d", it.ic, it.fu), 16'(take_branch), 16'(it.br));
        @(posedge clk); #2;
        // R5 R6 R7: flags after the edge
        check($sformatf("R5/R6/R7 flags ic=%0d fn=%0d", it.ic, it.fu),
              16'({flag_z, flag_s, flag_o}), 16'(it.f));
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R4 reset flags", 16'({flag_z, flag_s, flag_o}), 16'(3'b100));
    @(negedge clk); rst = 1'b0;
    drive(4'd3, 4'd0, 8'h11, 8'h22, 8'h35);   // R1 R2 immediate: c+0
    drive(4'd2, 4'd0, 8'h5A, 8'h22, 8'h35);   // register move: a+0
    drive(4'd4, 4'd0, 8'h11, 8'h20, 8'h08);   // c+b
    drive(4'd5, 4'd0, 8'h11, 8'h30, 8'hF0);
    drive(4'd10, 4'd0, 8'h11, 8'h40, 8'h00);  // -4
    drive(4'd8, 4'd0, 8'h11, 8'h02, 8'h00);   // -4 wrap
    drive(4'd9, 4'd0, 8'h11, 8'hFE, 8'h00);   // +4 wrap
    drive(4'd11, 4'd0, 8'h11, 8'h3C, 8'h00);
    drive(4'd0, 4'd0, 8'h11, 8'h3C, 8'h77);   // halt: 0+b
    drive(4'd6, 4'd0, 8'h01, 8'h7F, 8'h00);   // R7 add overflow
    drive(4'd1, 4'd0, 8'h01, 8'h7F, 8'h00);   // R5 hold
    for (int j = 0; j < 9; j++) drive(4'd7, 4'(j), 8'h0, 8'h0, 8'h0);
    drive(4'd6, 4'd1, 8'h33, 8'h33, 8'h00);   // R6 sub zero
    for (int j = 0; j < 9; j++) drive(4'd7, 4'(j), 8'h0, 8'h0, 8'h0);
    drive(4'd6, 4'd1, 8'h01, 8'h80, 8'h00);   // R7 sub overflow
    drive(4'd6, 4'd3, 8'hFF, 8'h0F, 8'h00);   // R7 xor clears ovf, sign set
    for (int j = 0; j < 9; j++) drive(4'd7, 4'(j), 8'h0, 8'h0, 8'h0);
    drive(4'd6, 4'd2, 8'h0F, 8'hF3, 8'h00);   // and, positive nonzero
    for (int j = 0; j < 9; j++) drive(4'd7, 4'(j), 8'h0, 8'h0, 8'h0);
    drive(4'd6, 4'd0, 8'h90, 8'h90, 8'h00);   // negative overflow
    drive(4'd7, 4'd15, 8'h0, 8'h0, 8'h0);     // R9 unused code
    drive(4'd7, 4'd2, 8'h0, 8'h0, 8'h0);
    drive(4'd6, 4'd1, 8'h05, 8'h02, 8'h00);   // negative, no ovf
    drive(4'd7, 4'd2, 8'h0, 8'h0, 8'h0);
    drive(4'd7, 4'd6, 8'h0, 8'h0, 8'h0);
    drive(4'd1, 4'd0, 8'h0, 8'h0, 8'h0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule